// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Flag Generation

This block is the execution stage of an 8-bit accumulator machine. On each clock it takes two operands, a 4-bit operation code and the current carry, overflow and half-carry flags. It computes an 8-bit result and a new set of condition flags: negative (N), zero (Z), carry (C), overflow (V) and half-carry (H). The outputs are registered, so every result appears one clock after its inputs were presented.

The result and each flag come with a write enable. The surrounding register file commits only the values whose enable is high. A flag output whose enable is low reads 0.

Subtraction and compare invert the second operand and add it with a carry. A set carry therefore means "no borrow". Operand fetch, addressing and register storage are handled elsewhere.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, every output is 0. Each operation's outputs appear on the clock edge that follows the edge sampling its inputs.
- R2: Code 1 (add with carry) gives `res_o` = A + B + `c_i` modulo 256 and raises `res_we_o`. C is the carry out of bit 7. All five flag enables are high.
- R3: For codes 1 and 2, V is set when the signed 8-bit sum of A, the effective second operand and `c_i` falls outside -128..127. H is set on a carry out of bit 3 of the low-nibble addition, carry-in included.
- R4: Code 2 (subtract with carry) adds A, the bitwise inverse of B and `c_i`. With `c_i` = 1 this is A - B, and C = 1 reports that no borrow occurred. Its enables match code 1.
- R5: Code 3 (compare) shows A - B modulo 256 on `res_o` with `res_we_o` low. C is 1 exactly when A >= B unsigned. N, Z and C are enabled; V and H are not.
- R6: Codes 4, 5 and 6 write A AND B, A OR B and A XOR B respectively. Only the N and Z enables are high.
- R7: Code 7 (shift left) shifts a 0 into bit 0. Code 8 (rotate left) shifts `c_i` into bit 0. Both write the old bit 7 to C and enable N, Z and C.
- R8: Code 9 (shift right) shifts a 0 into bit 7. Code 10 (rotate right) shifts `c_i` into bit 7. Both write the old bit 0 to C and enable N, Z and C.
- R9: Code 11 writes A + 1 and code 12 writes A - 1, both wrapping modulo 256. Only the N and Z enables are high; C is never enabled.
- R10: Code 13 writes A with bits 7:4 and 3:0 exchanged and enables N and Z.
- R11: Whenever the N/Z enables are high, N equals `res_o` bit 7 and Z is 1 exactly when `res_o` is zero.
- R12: Code 14 (clear overflow) raises only the V and H enables, with V = H = 0. `res_we_o` is low and `res_o` is 0.
- R13: Codes 0 and 15 raise no enable and drive `res_o` and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| h_i | input | 1 | Incoming half-carry flag |
| res_o | output | 8 | Result value |
| res_we_o | output | 1 | Result write enable |
| n_o | output | 1 | New negative flag |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |
| v_o | output | 1 | New overflow flag |
| h_o | output | 1 | New half-carry flag |
| n_we_o | output | 1 | Negative flag update enable |
| z_we_o | output | 1 | Zero flag update enable |
| c_we_o | output | 1 | Carry flag update enable |
| v_we_o | output | 1 | Overflow flag update enable |
| h_we_o | output | 1 | Half-carry flag update enable |

## Verification
Two things meet in the same cycle: the incoming carry is consumed by add, subtract and the rotates, and a new carry is produced that replaces it. The bench drives random operation codes back to back with a random `c_i` on every cycle, so carry-in and carry-out interact on adjacent cycles. Directed cases add nibble and sign boundaries, such as 0x7F+1, 0xFF+1, 0x80-1 and the rotates with a set carry. Every registered output set is compared in full against a reference function written from the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SBC  = 4'd2,
        OP_CMP  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_ASL  = 4'd7,
        OP_ROL  = 4'd8,
        OP_LSR  = 4'd9,
        OP_ROR  = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_SWAP = 4'd13,
        OP_CLRV = 4'd14,
        OP_IDLE = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
        logic h;
    } flag_set_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              res_we;
        flag_set_t         val;
        flag_set_t         we;
    } alu_state_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         invert_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o,
    output logic         half_o
);
    localparam int NW = W / 2;

    logic [W-1:0]  b_eff;
    logic [W:0]    full_sum;
    logic [NW:0]   low_sum;

    always_comb begin
        b_eff    = invert_i ? ~b_i : b_i;
        full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
        low_sum  = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin_i};
        sum_o    = full_sum[W-1:0];
        cout_o   = full_sum[W];
        half_o   = low_sum[NW];
        ovf_o    = (a_i[W-1] == b_eff[W-1]) && (full_sum[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         right_i,
    input  logic         use_carry_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic fill;

    always_comb begin
        fill = use_carry_i & cin_i;
        if (right_i) begin
            res_o  = {fill, a_i[W-1:1]};
            cout_o = a_i[0];
        end else begin
            res_o  = {a_i[W-2:0], fill};
            cout_o = a_i[W-1];
        end
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
    parameter int W = 8
) (
    input  logic [W-1:0]          a_i,
    input  logic [W-1:0]          b_i,
    input  alu8_pkg::alu_op_e     op_i,
    output logic [W-1:0]          res_o
);
    localparam int NW = W / 2;

    logic [W-1:0] swapped;

    for (genvar i = 0; i < NW; i++) begin : g_swap
        assign swapped[i]      = a_i[i + NW];
        assign swapped[i + NW] = a_i[i];
    end

    always_comb begin
        unique case (op_i)
            alu8_pkg::OP_AND:  res_o = a_i & b_i;
            alu8_pkg::OP_OR:   res_o = a_i | b_i;
            alu8_pkg::OP_XOR:  res_o = a_i ^ b_i;
            alu8_pkg::OP_INC:  res_o = a_i + {{(W-1){1'b0}}, 1'b1};
            alu8_pkg::OP_DEC:  res_o = a_i - {{(W-1){1'b0}}, 1'b1};
            alu8_pkg::OP_SWAP: res_o = swapped;
            default:           res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    input  logic              v_i,
    input  logic              h_i,
    output logic [DATA_W-1:0] res_o,
    output logic              res_we_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              v_o,
    output logic              h_o,
    output logic              n_we_o,
    output logic              z_we_o,
    output logic              c_we_o,
    output logic              v_we_o,
    output logic              h_we_o
);
    alu_op_e           op;
    logic [DATA_W-1:0] add_sum;
    logic              add_co;
    logic              add_ov;
    logic              add_hc;
    logic [DATA_W-1:0] sh_res;
    logic              sh_co;
    logic [DATA_W-1:0] bit_res;
    alu_state_t        st_d;
    alu_state_t        st_q;

    assign op = alu_op_e'(op_i);

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a_i      (a_i),
        .b_i      (b_i),
        .invert_i (op != OP_ADC),
        .cin_i    ((op == OP_CMP) ? 1'b1 : c_i),
        .sum_o    (add_sum),
        .cout_o   (add_co),
        .ovf_o    (add_ov),
        .half_o   (add_hc)
    );

    alu8_shift #(.W(DATA_W)) u_shift (
        .a_i         (a_i),
        .cin_i       (c_i),
        .right_i     ((op == OP_LSR) || (op == OP_ROR)),
        .use_carry_i ((op == OP_ROL) || (op == OP_ROR)),
        .res_o       (sh_res),
        .cout_o      (sh_co)
    );

    alu8_bitops #(.W(DATA_W)) u_bitops (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op),
        .res_o (bit_res)
    );

    always_comb begin
        st_d = '0;
        unique case (op)
            OP_ADC, OP_SBC: begin
                st_d.res    = add_sum;
                st_d.res_we = 1'b1;
                st_d.val.c  = add_co;
                st_d.val.v  = add_ov;
                st_d.val.h  = add_hc;
                st_d.we     = '1;
            end
            OP_CMP: begin
                st_d.res   = add_sum;
                st_d.val.c = add_co;
                st_d.we.n  = 1'b1;
                st_d.we.z  = 1'b1;
                st_d.we.c  = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_SWAP: begin
                st_d.res    = bit_res;
                st_d.res_we = 1'b1;
                st_d.we.n   = 1'b1;
                st_d.we.z   = 1'b1;
            end
            OP_ASL, OP_ROL, OP_LSR, OP_ROR: begin
                st_d.res    = sh_res;
                st_d.res_we = 1'b1;
                st_d.val.c  = sh_co;
                st_d.we.n   = 1'b1;
                st_d.we.z   = 1'b1;
                st_d.we.c   = 1'b1;
            end
            OP_CLRV: begin
                st_d.we.v = 1'b1;
                st_d.we.h = 1'b1;
            end
            default: st_d = '0;
        endcase
        if (st_d.we.n) begin
            st_d.val.n = st_d.res[DATA_W-1];
            st_d.val.z = (st_d.res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o    = st_q.res;
    assign res_we_o = st_q.res_we;
    assign n_o      = st_q.val.n;
    assign z_o      = st_q.val.z;
    assign c_o      = st_q.val.c;
    assign v_o      = st_q.val.v;
    assign h_o      = st_q.val.h;
    assign n_we_o   = st_q.we.n;
    assign z_we_o   = st_q.we.z;
    assign c_we_o   = st_q.we.c;
    assign v_we_o   = st_q.we.v;
    assign h_we_o   = st_q.we.h;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              c_i,
    input logic [DATA_W-1:0] res_o,
    input logic              res_we_o,
    input logic              n_o,
    input logic              z_o,
    input logic              c_o,
    input logic              v_o,
    input logic              h_o,
    input logic              n_we_o,
    input logic              z_we_o,
    input logic              c_we_o,
    input logic              v_we_o,
    input logic              h_we_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_nz_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        n_we_o |-> (n_o == res_o[DATA_W-1]) && (z_o == (res_o == '0)));

    assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd1) |->
        (res_we_o && res_o == DATA_W'($past(a_i) + $past(b_i) + {{(DATA_W-1){1'b0}}, $past(c_i)})));

    assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd3) |->
        (!res_we_o && !v_we_o && !h_we_o && c_we_o && (c_o == ($past(a_i) >= $past(b_i)))));

    assert_logic_nz_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 4'd4 && $past(op_i) <= 4'd6) |->
        (n_we_o && z_we_o && !c_we_o && !v_we_o && !h_we_o));

    assert_shl_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd7) |->
        (res_o == {$past(a_i[DATA_W-2:0]), 1'b0} && c_o == $past(a_i[DATA_W-1])));

    assert_incdec_keep_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_i) == 4'd11 || $past(op_i) == 4'd12)) |-> !c_we_o);

    assert_clear_vh_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd14) |->
        (v_we_o && h_we_o && !v_o && !h_o && !res_we_o && !c_we_o && !n_we_o && !z_we_o));
endmodule

bind alu8_core alu8_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .c_i      (c_i),
    .res_o    (res_o),
    .res_we_o (res_we_o),
    .n_o      (n_o),
    .z_o      (z_o),
    .c_o      (c_o),
    .v_o      (v_o),
    .h_o      (h_o),
    .n_we_o   (n_we_o),
    .z_we_o   (z_we_o),
    .c_we_o   (c_we_o),
    .v_we_o   (v_we_o),
    .h_we_o   (h_we_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    typedef struct packed {
        logic [7:0] res;
        logic       res_we;
        logic       n, z, c, v, h;
        logic       nwe, zwe, cwe, vwe, hwe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic       c_i = 1'b0, v_i = 1'b0, h_i = 1'b0;
    logic [7:0] res_o;
    logic       res_we_o, n_o, z_o, c_o, v_o, h_o;
    logic       n_we_o, z_we_o, c_we_o, v_we_o, h_we_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .c_i(c_i), .v_i(v_i), .h_i(h_i), .res_o(res_o), .res_we_o(res_we_o),
        .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o), .h_o(h_o),
        .n_we_o(n_we_o), .z_we_o(z_we_o), .c_we_o(c_we_o),
        .v_we_o(v_we_o), .h_we_o(h_we_o)
    );

    function automatic int sx(input logic [7:0] x);
        return (x > 8'd127) ? int'(x) - 256 : int'(x);
    endfunction

    function automatic exp_t model(input logic [3:0] op, input logic [7:0] a,
                                   input logic [7:0] b, input logic ci);
        exp_t e;
        logic [7:0] bb;
        int s, ss;
        e = '0;
        case (op)
            4'd1, 4'd2: begin
                bb = (op == 4'd2) ? ~b : b;
                s  = int'(a) + int'(bb) + int'(ci);
                ss = sx(a) + sx(bb) + int'(ci);
                e.res = s[7:0]; e.res_we = 1'b1;
                e.c = (s > 255);
                e.v = (ss > 127) || (ss < -128);
                e.h = ((int'(a[3:0]) + int'(bb[3:0]) + int'(ci)) > 15);
                {e.nwe, e.zwe, e.cwe, e.vwe, e.hwe} = '1;
            end
            4'd3: begin
                e.res = a - b; e.c = (a >= b);
                {e.nwe, e.zwe, e.cwe} = '1;
            end
            4'd4, 4'd5, 4'd6, 4'd11, 4'd12, 4'd13: begin
                case (op)
                    4'd4:    e.res = a & b;
                    4'd5:    e.res = a | b;
                    4'd6:    e.res = a ^ b;
                    4'd11:   e.res = a + 8'd1;
                    4'd12:   e.res = a - 8'd1;
                    default: e.res = {a[3:0], a[7:4]};
                endcase
                e.res_we = 1'b1; {e.nwe, e.zwe} = '1;
            end
            4'd7, 4'd8: begin
                e.res = {a[6:0], (op == 4'd8) ? ci : 1'b0}; e.c = a[7];
                e.res_we = 1'b1; {e.nwe, e.zwe, e.cwe} = '1;
            end
            4'd9, 4'd10: begin
                e.res = {(op == 4'd10) ? ci : 1'b0, a[7:1]}; e.c = a[0];
                e.res_we = 1'b1; {e.nwe, e.zwe, e.cwe} = '1;
            end
            4'd14: {e.vwe, e.hwe} = '1;
            default: e = '0;
        endcase
        if (e.nwe) begin
            e.n = e.res[7];
            e.z = (e.res == 8'd0);
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd1:               return "R2 R3";
            4'd2:               return "R4 R3";
            4'd3:               return "R5";
            4'd4, 4'd5, 4'd6:   return "R6";
            4'd7, 4'd8:         return "R7";
            4'd9, 4'd10:        return "R8";
            4'd11, 4'd12:       return "R9";
            4'd13:              return "R10";
            4'd14:              return "R12";
            default:            return "R13";
        endcase
    endfunction

    function automatic exp_t observed();
        exp_t o;
        o = {res_o, res_we_o, n_o, z_o, c_o, v_o, h_o,
             n_we_o, z_we_o, c_we_o, v_we_o, h_we_o};
        return o;
    endfunction

    task automatic compare(input string tag, input exp_t exp);
        exp_t got;
        got = observed();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual res=%02h we=%b nzcvh=%b%b%b%b%b en=%b%b%b%b%b expected res=%02h we=%b nzcvh=%b%b%b%b%b en=%b%b%b%b%b",
                tag, got.res, got.res_we, got.n, got.z, got.c, got.v, got.h,
                got.nwe, got.zwe, got.cwe, got.vwe, got.hwe,
                exp.res, exp.res_we, exp.n, exp.z, exp.c, exp.v, exp.h,
                exp.nwe, exp.zwe, exp.cwe, exp.vwe, exp.hwe);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic ci, input logic vi, input logic hi, input string tag);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; c_i = ci; v_i = vi; h_i = hi;
        @(negedge clk);
        compare(tag, model(op, a, b, ci));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        op_i = 4'd1; a_i = 8'hFF; b_i = 8'hFF; c_i = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1 reset", '0);
        rst_n = 1'b1;

        run_op(4'd1, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0, "R3 signed overflow and half carry");
        run_op(4'd1, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, "R2 carry out zero result");
        run_op(4'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R11 zero flag");
        run_op(4'd1, 8'h0F, 8'h00, 1'b1, 1'b0, 1'b0, "R3 half carry from carry in");
        run_op(4'd2, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, "R4 borrow");
        run_op(4'd2, 8'h80, 8'h01, 1'b1, 1'b0, 1'b0, "R4 R3 overflow");
        run_op(4'd2, 8'h05, 8'h03, 1'b0, 1'b0, 1'b0, "R4 pending borrow");
        run_op(4'd3, 8'h42, 8'h42, 1'b0, 1'b1, 1'b1, "R5 equal");
        run_op(4'd3, 8'h03, 8'h05, 1'b1, 1'b1, 1'b1, "R5 less");
        run_op(4'd11, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, "R9 inc wrap");
        run_op(4'd12, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R9 dec wrap");
        run_op(4'd8, 8'h80, 8'h00, 1'b1, 1'b0, 1'b0, "R7 rotate left carry");
        run_op(4'd7, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0, "R7 shift left");
        run_op(4'd10, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, "R8 rotate right carry");
        run_op(4'd9, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0, "R8 shift right");
        run_op(4'd13, 8'hA5, 8'h00, 1'b0, 1'b0, 1'b0, "R10 swap");
        run_op(4'd4, 8'hF0, 8'h0F, 1'b1, 1'b1, 1'b1, "R6 and zero");
        run_op(4'd14, 8'h12, 8'h34, 1'b1, 1'b1, 1'b1, "R12 clear");
        run_op(4'd0, 8'h12, 8'h34, 1'b1, 1'b1, 1'b1, "R13 code 0");
        run_op(4'd15, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, "R13 code 15");

        for (int i = 0; i < 4000; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            run_op(op, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), tag_of(op));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule